// File: doc/BRIEF.md
# Interlaced SD Video Sync Timing Generator

This block produces line and field timing for an interlaced standard-definition composite video encoder. A one-bit standard select chooses between the 525-line and the 625-line television system. The horizontal counter always runs free at the line length that the selected system fixes. Upstream timing cannot stretch or shorten a line, because the encoder that follows expects exactly that period.

Vertically the block accepts an optional restart pulse from the upstream pixel pipeline. The pulse ends the current frame at the next line boundary, which gives shorter non-standard frames. One example is a 525-line raster while running with 625-line line timing. If no pulse arrives, the block restarts the frame by itself when the system's line limit is reached. A frame can never be longer than that limit.

Each restart toggles the field flag. In the second field the vertical sync window is shifted by half a line. The standard select is taken over only at a frame restart. All counters advance only on clocks where the pixel enable is high. The nominal pixel rate is 13.5 MHz.

Top module: `tv_sync_gen`

## Requirements
- R1: While reset is asserted and right after it, the pixel counter and the line counter are 0, the field flag is 0, the 525-line system is in effect, and hsync and vsync are low.
- R2: On each enabled clock the pixel counter steps by one and wraps to 0 after the last pixel of the line. The line has 858 pixels in the 525-line system and 864 in the 625-line system. The line counter steps at that wrap. The restart pulse never changes the line length.
- R3: hsync is high exactly while the pixel counter is at or after the sync start and before the sync end. These are pixels 734 to 797 in the 525-line system and pixels 740 to 803 in the 625-line system.
- R4: When the last line of the system's limit ends, the line counter returns to 0 with the pixel counter. That last line is line 524 in the 525-line system and line 624 in the 625-line system.
- R5: The field flag toggles at every frame restart. In field 0, vsync is high from pixel 0 of the start line up to, but not including, pixel 0 of the end line. In field 1 both edges move to pixel (line length)/2. The start and end lines are 487 and 493 in the 525-line system and 486 and 492 in the 625-line system.
- R6: A restart pulse sampled on an enabled clock makes the frame restart at the first line wrap after that clock. The field toggles as in R5.
- R7: A restart pulse that falls in the last line before the limit is absorbed by the limit restart. The frame that follows runs past line 0 at its full length.
- R8: std_sel_i (0 = 525-line, 1 = 625-line) is taken over only at a frame restart. A change in the middle of a frame leaves the running frame's line length and limit unchanged.
- R9: While pix_en_i is low, the counters and the field flag hold, and a restart pulse is not sampled.
- R10: active_o is high exactly when the pixel counter is below 720 and the line counter is below 480.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| std_sel_i | input | 1 | System select: 0 = 525-line, 1 = 625-line |
| pix_en_i | input | 1 | Pixel clock enable |
| vsync_trig_i | input | 1 | Upstream frame restart pulse |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync, shifted half a line in field 1 |
| field_o | output | 1 | Current field |
| active_o | output | 1 | Inside the active picture window |
| h_cnt_o | output | $clog2(max line length), 10 by default | Pixel counter |
| v_cnt_o | output | $clog2(max line limit), 10 by default | Line counter |

## Verification
A wrong pixel count shows up within one line. hsync lands at the wrong place and h_cnt_o wraps at the wrong value. A restart pulse that stays pending too long, or is lost, shows at the next line wrap, as a frame that is one line long or one that does not restart. A wrong field or a standard select taken over at the wrong time moves the vsync edges by half a line, or changes the line length and limit in the next frame. All of this can be seen within one frame.

// File: rtl/tv_sync_pkg.sv
package tv_sync_pkg;
  typedef enum logic {
    STD_525 = 1'b0,
    STD_625 = 1'b1
  } tv_std_e;
endpackage

// File: rtl/tv_line_timer.sv
module tv_line_timer
  import tv_sync_pkg::*;
#(
  parameter int HW           = 10,
  parameter int H_TOTAL_525  = 858,
  parameter int H_TOTAL_625  = 864,
  parameter int HS_START_525 = 734,
  parameter int HS_END_525   = 798,
  parameter int HS_START_625 = 740,
  parameter int HS_END_625   = 804
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_en_i,
  input  tv_std_e       std_i,
  output logic [HW-1:0] h_cnt_o,
  output logic          line_end_o,
  output logic          hsync_o
);
  localparam logic [HW-1:0] LAST_525 = HW'(H_TOTAL_525 - 1);
  localparam logic [HW-1:0] LAST_625 = HW'(H_TOTAL_625 - 1);
  localparam logic [HW-1:0] HSS_525  = HW'(HS_START_525);
  localparam logic [HW-1:0] HSE_525  = HW'(HS_END_525);
  localparam logic [HW-1:0] HSS_625  = HW'(HS_START_625);
  localparam logic [HW-1:0] HSE_625  = HW'(HS_END_625);

  logic [HW-1:0] h_q, last, hs_s, hs_e;

  always_comb begin
    last = (std_i == STD_625) ? LAST_625 : LAST_525;
    hs_s = (std_i == STD_625) ? HSS_625  : HSS_525;
    hs_e = (std_i == STD_625) ? HSE_625  : HSE_525;
  end

  assign line_end_o = pix_en_i && (h_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       h_q <= '0;
    else if (pix_en_i) h_q <= (h_q == last) ? '0 : h_q + 1'b1;
  end

  assign h_cnt_o = h_q;
  assign hsync_o = (h_q >= hs_s) && (h_q < hs_e);
endmodule

// File: rtl/tv_frame_timer.sv
module tv_frame_timer
  import tv_sync_pkg::*;
#(
  parameter int VW          = 10,
  parameter int V_LIMIT_525 = 525,
  parameter int V_LIMIT_625 = 625
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_en_i,
  input  logic          trig_i,
  input  logic          line_end_i,
  input  logic          std_sel_i,
  output logic [VW-1:0] v_cnt_o,
  output logic          field_o,
  output tv_std_e       std_o
);
  localparam logic [VW-1:0] VLAST_525 = VW'(V_LIMIT_525 - 1);
  localparam logic [VW-1:0] VLAST_625 = VW'(V_LIMIT_625 - 1);

  logic [VW-1:0] v_q, vlast;
  logic          field_q, pend_q, restart;
  tv_std_e       std_q;

  assign vlast   = (std_q == STD_625) ? VLAST_625 : VLAST_525;
  // early trigger or limit reached; both resolve at a line boundary
  assign restart = line_end_i && (pend_q || (v_q == vlast));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q     <= '0;
      field_q <= 1'b0;
      pend_q  <= 1'b0;
      std_q   <= STD_525;
    end else if (restart) begin
      v_q     <= '0;
      field_q <= ~field_q;
      pend_q  <= 1'b0;
      std_q   <= tv_std_e'(std_sel_i);
    end else begin
      if (line_end_i)          v_q    <= v_q + 1'b1;
      if (pix_en_i && trig_i)  pend_q <= 1'b1;
    end
  end

  assign v_cnt_o = v_q;
  assign field_o = field_q;
  assign std_o   = std_q;
endmodule

// File: rtl/tv_field_decode.sv
module tv_field_decode
  import tv_sync_pkg::*;
#(
  parameter int HW           = 10,
  parameter int VW           = 10,
  parameter int H_TOTAL_525  = 858,
  parameter int H_TOTAL_625  = 864,
  parameter int H_ACTIVE     = 720,
  parameter int V_ACTIVE     = 480,
  parameter int VS_START_525 = 487,
  parameter int VS_END_525   = 493,
  parameter int VS_START_625 = 486,
  parameter int VS_END_625   = 492
) (
  input  logic [HW-1:0] h_i,
  input  logic [VW-1:0] v_i,
  input  logic          field_i,
  input  tv_std_e       std_i,
  output logic          vsync_o,
  output logic          active_o
);
  localparam logic [HW-1:0] HALF_525 = HW'(H_TOTAL_525 / 2);
  localparam logic [HW-1:0] HALF_625 = HW'(H_TOTAL_625 / 2);
  localparam logic [HW-1:0] HA_L     = HW'(H_ACTIVE);
  localparam logic [VW-1:0] VA_L     = VW'(V_ACTIVE);
  localparam logic [VW-1:0] VSS_525  = VW'(VS_START_525);
  localparam logic [VW-1:0] VSE_525  = VW'(VS_END_525);
  localparam logic [VW-1:0] VSS_625  = VW'(VS_START_625);
  localparam logic [VW-1:0] VSE_625  = VW'(VS_END_625);

  logic [HW-1:0] off;
  logic [VW-1:0] vs_s, vs_e;
  logic          past_start, before_end;

  always_comb begin
    vs_s = (std_i == STD_625) ? VSS_625 : VSS_525;
    vs_e = (std_i == STD_625) ? VSE_625 : VSE_525;
    // second field: both vsync edges delayed by half a line
    if (field_i) off = (std_i == STD_625) ? HALF_625 : HALF_525;
    else         off = '0;
    past_start = (v_i > vs_s) || ((v_i == vs_s) && (h_i >= off));
    before_end = (v_i < vs_e) || ((v_i == vs_e) && (h_i < off));
  end

  assign vsync_o  = past_start && before_end;
  assign active_o = (h_i < HA_L) && (v_i < VA_L);
endmodule

// File: rtl/tv_sync_gen.sv
module tv_sync_gen
  import tv_sync_pkg::*;
#(
  parameter int H_TOTAL_525  = 858,
  parameter int H_TOTAL_625  = 864,
  parameter int H_ACTIVE     = 720,
  parameter int HS_START_525 = 734,
  parameter int HS_END_525   = 798,
  parameter int HS_START_625 = 740,
  parameter int HS_END_625   = 804,
  parameter int V_LIMIT_525  = 525,
  parameter int V_LIMIT_625  = 625,
  parameter int V_ACTIVE     = 480,
  parameter int VS_START_525 = 487,
  parameter int VS_END_525   = 493,
  parameter int VS_START_625 = 486,
  parameter int VS_END_625   = 492,
  localparam int H_MAX = (H_TOTAL_625 > H_TOTAL_525) ? H_TOTAL_625 : H_TOTAL_525,
  localparam int V_MAX = (V_LIMIT_625 > V_LIMIT_525) ? V_LIMIT_625 : V_LIMIT_525,
  localparam int HW    = $clog2(H_MAX),
  localparam int VW    = $clog2(V_MAX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          std_sel_i,
  input  logic          pix_en_i,
  input  logic          vsync_trig_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          field_o,
  output logic          active_o,
  output logic [HW-1:0] h_cnt_o,
  output logic [VW-1:0] v_cnt_o
);
  tv_std_e std_q;
  logic    line_end;

  tv_line_timer #(
    .HW(HW), .H_TOTAL_525(H_TOTAL_525), .H_TOTAL_625(H_TOTAL_625),
    .HS_START_525(HS_START_525), .HS_END_525(HS_END_525),
    .HS_START_625(HS_START_625), .HS_END_625(HS_END_625)
  ) u_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .pix_en_i(pix_en_i), .std_i(std_q),
    .h_cnt_o(h_cnt_o), .line_end_o(line_end), .hsync_o(hsync_o)
  );

  tv_frame_timer #(
    .VW(VW), .V_LIMIT_525(V_LIMIT_525), .V_LIMIT_625(V_LIMIT_625)
  ) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .pix_en_i(pix_en_i), .trig_i(vsync_trig_i),
    .line_end_i(line_end), .std_sel_i(std_sel_i),
    .v_cnt_o(v_cnt_o), .field_o(field_o), .std_o(std_q)
  );

  tv_field_decode #(
    .HW(HW), .VW(VW), .H_TOTAL_525(H_TOTAL_525), .H_TOTAL_625(H_TOTAL_625),
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE),
    .VS_START_525(VS_START_525), .VS_END_525(VS_END_525),
    .VS_START_625(VS_START_625), .VS_END_625(VS_END_625)
  ) u_dec (
    .h_i(h_cnt_o), .v_i(v_cnt_o), .field_i(field_o), .std_i(std_q),
    .vsync_o(vsync_o), .active_o(active_o)
  );
endmodule

// File: rtl/tv_sync_chk.sv
module tv_sync_chk
  import tv_sync_pkg::*;
#(
  parameter int HW           = 10,
  parameter int VW           = 10,
  parameter int H_TOTAL_525  = 858,
  parameter int H_TOTAL_625  = 864,
  parameter int HS_START_525 = 734,
  parameter int HS_START_625 = 740,
  parameter int V_LIMIT_525  = 525,
  parameter int V_LIMIT_625  = 625
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_en_i,
  input  tv_std_e       std_q,
  input  logic [HW-1:0] h_cnt,
  input  logic [VW-1:0] v_cnt,
  input  logic          field,
  input  logic          hsync
);
  logic [HW-1:0] h_last, hs_s;
  logic [VW-1:0] v_last;

  assign h_last = (std_q == STD_625) ? HW'(H_TOTAL_625 - 1) : HW'(H_TOTAL_525 - 1);
  assign hs_s   = (std_q == STD_625) ? HW'(HS_START_625) : HW'(HS_START_525);
  assign v_last = (std_q == STD_625) ? VW'(V_LIMIT_625 - 1) : VW'(V_LIMIT_525 - 1);

  assert_h_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_cnt <= h_last);

  assert_hsync_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hsync) |-> h_cnt == hs_s);

  assert_v_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_cnt <= v_last);

  assert_field_at_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(field) |-> (h_cnt == '0) && (v_cnt == '0));

  assert_std_at_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(std_q) |-> (h_cnt == '0) && (v_cnt == '0));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> $stable(h_cnt) && $stable(v_cnt) && $stable(field));
endmodule

bind tv_sync_gen tv_sync_chk #(
  .HW(HW), .VW(VW), .H_TOTAL_525(H_TOTAL_525), .H_TOTAL_625(H_TOTAL_625),
  .HS_START_525(HS_START_525), .HS_START_625(HS_START_625),
  .V_LIMIT_525(V_LIMIT_525), .V_LIMIT_625(V_LIMIT_625)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pix_en_i(pix_en_i), .std_q(std_q),
  .h_cnt(h_cnt_o), .v_cnt(v_cnt_o), .field(field_o), .hsync(hsync_o)
);

// File: tb/tv_sync_gen_tb.sv
module tv_sync_gen_tb;
  // scaled-down timing so whole frames fit in a short run
  localparam int HT_A = 20, HT_B = 24, HA = 12;
  localparam int HSS_A = 14, HSE_A = 17, HSS_B = 15, HSE_B = 19;
  localparam int VL_A = 10, VL_B = 13, VA = 6;
  localparam int VSS_A = 7, VSE_A = 9, VSS_B = 6, VSE_B = 8;
  localparam int HW = $clog2(HT_B);
  localparam int VW = $clog2(VL_B);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic std_sel = 1'b0, pix_en = 1'b0, trig = 1'b0;
  logic hsync, vsync, field, active;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  tv_sync_gen #(
    .H_TOTAL_525(HT_A), .H_TOTAL_625(HT_B), .H_ACTIVE(HA),
    .HS_START_525(HSS_A), .HS_END_525(HSE_A),
    .HS_START_625(HSS_B), .HS_END_625(HSE_B),
    .V_LIMIT_525(VL_A), .V_LIMIT_625(VL_B), .V_ACTIVE(VA),
    .VS_START_525(VSS_A), .VS_END_525(VSE_A),
    .VS_START_625(VSS_B), .VS_END_625(VSE_B)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .std_sel_i(std_sel), .pix_en_i(pix_en),
    .vsync_trig_i(trig), .hsync_o(hsync), .vsync_o(vsync), .field_o(field),
    .active_o(active), .h_cnt_o(h_cnt), .v_cnt_o(v_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (h=%0d v=%0d)", req, act, exp, h_cnt, v_cnt);
    end
  endtask

  task automatic tick(input logic en, input logic tg);
    @(negedge clk);
    pix_en = en;
    trig   = tg;
    @(posedge clk);
    #2;
  endtask

  task automatic advance_to(input string req, input int h, input int v);
    int n = 0;
    while (!(int'(h_cnt) == h && int'(v_cnt) == v) && n < 1000) begin
      tick(1'b1, 1'b0);
      n++;
    end
    if (n >= 1000) check({req, " reach position"}, int'(v_cnt) * 100 + int'(h_cnt), v * 100 + h);
  endtask

  task automatic t_reset;
    check("R1 h", int'(h_cnt), 0);
    check("R1 v", int'(v_cnt), 0);
    check("R1 field", int'(field), 0);
    check("R1 hsync", int'(hsync), 0);
    check("R1 vsync", int'(vsync), 0);
  endtask

  task automatic t_line;
    advance_to("R10", HA - 1, 0);
    check("R10 active last pixel", int'(active), 1);
    tick(1'b1, 1'b0);
    check("R10 active past width", int'(active), 0);
    advance_to("R3", HSS_A - 1, 0);
    check("R3 hsync before start", int'(hsync), 0);
    tick(1'b1, 1'b0);
    check("R3 hsync at start", int'(hsync), 1);
    advance_to("R3", HSE_A - 1, 0);
    check("R3 hsync last", int'(hsync), 1);
    tick(1'b1, 1'b0);
    check("R3 hsync at end", int'(hsync), 0);
    advance_to("R2", HT_A - 1, 0);
    tick(1'b1, 1'b0);
    check("R2 h wrap 525", int'(h_cnt), 0);
    check("R2 v step", int'(v_cnt), 1);
    advance_to("R10", 0, VA - 1);
    check("R10 active last line", int'(active), 1);
    advance_to("R10", 0, VA);
    check("R10 active past height", int'(active), 0);
  endtask

  task automatic t_frame;
    advance_to("R5", HT_A - 1, VSS_A - 1);
    check("R5 f0 vsync before", int'(vsync), 0);
    tick(1'b1, 1'b0);
    check("R5 f0 vsync start", int'(vsync), 1);
    advance_to("R5", HT_A - 1, VSE_A - 1);
    check("R5 f0 vsync last", int'(vsync), 1);
    tick(1'b1, 1'b0);
    check("R5 f0 vsync end", int'(vsync), 0);
    advance_to("R4", HT_A - 1, VL_A - 1);
    check("R4 field before wrap", int'(field), 0);
    tick(1'b1, 1'b0);
    check("R4 v restart", int'(v_cnt), 0);
    check("R5 field toggled", int'(field), 1);
    advance_to("R5", HT_A / 2 - 1, VSS_A);
    check("R5 f1 vsync before half", int'(vsync), 0);
    tick(1'b1, 1'b0);
    check("R5 f1 vsync at half", int'(vsync), 1);
    advance_to("R5", HT_A / 2 - 1, VSE_A);
    check("R5 f1 vsync last", int'(vsync), 1);
    tick(1'b1, 1'b0);
    check("R5 f1 vsync end", int'(vsync), 0);
    advance_to("R4", HT_A - 1, VL_A - 1);
    tick(1'b1, 1'b0);
    check("R5 field back to 0", int'(field), 0);
  endtask

  task automatic t_trigger;
    logic f;
    advance_to("R6", 4, 3);
    f = field;
    tick(1'b1, 1'b1);
    check("R6 line kept after trigger", int'(v_cnt), 3);
    advance_to("R6", HT_A - 1, 3);
    tick(1'b1, 1'b0);
    check("R6 early restart v", int'(v_cnt), 0);
    check("R6 early restart h", int'(h_cnt), 0);
    check("R6 field toggled", int'(field), int'(!f));
  endtask

  task automatic t_last_line;
    advance_to("R7", 4, VL_A - 1);
    tick(1'b1, 1'b1);
    advance_to("R7", HT_A - 1, VL_A - 1);
    tick(1'b1, 1'b0);
    check("R7 limit restart", int'(v_cnt), 0);
    advance_to("R7", HT_A - 1, 0);
    tick(1'b1, 1'b0);
    check("R7 no extra restart", int'(v_cnt), 1);
  endtask

  task automatic t_std;
    logic f;
    advance_to("R8", 0, 2);
    std_sel = 1'b1;
    advance_to("R8", HT_A - 1, 2);
    tick(1'b1, 1'b0);
    check("R8 mid-frame line length kept", int'(h_cnt), 0);
    advance_to("R8", HT_A - 1, VL_A - 1);
    tick(1'b1, 1'b0);
    check("R8 restart at old limit", int'(v_cnt), 0);
    advance_to("R2", HT_A - 1, 0);
    tick(1'b1, 1'b0);
    check("R2 625 line longer", int'(h_cnt), HT_A);
    advance_to("R3", HSS_B - 1, 1);
    check("R3 625 hsync before", int'(hsync), 0);
    tick(1'b1, 1'b0);
    check("R3 625 hsync start", int'(hsync), 1);
    advance_to("R3", HSE_B - 1, 1);
    tick(1'b1, 1'b0);
    check("R3 625 hsync end", int'(hsync), 0);
    f = field;
    advance_to("R5", HT_B / 2 - 1, VSS_B);
    check("R5 625 vsync before half", int'(vsync), int'(!f));
    tick(1'b1, 1'b0);
    check("R5 625 vsync at half", int'(vsync), 1);
    advance_to("R4", HT_B - 1, VL_B - 1);
    tick(1'b1, 1'b0);
    check("R4 625 limit restart", int'(v_cnt), 0);
  endtask

  task automatic t_hold;
    int h0, v0, f0;
    advance_to("R9", 7, 4);
    h0 = int'(h_cnt); v0 = int'(v_cnt); f0 = int'(field);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
    check("R9 h held", int'(h_cnt), h0);
    check("R9 v held", int'(v_cnt), v0);
    check("R9 field held", int'(field), f0);
    advance_to("R9", HT_B - 1, 4);
    tick(1'b1, 1'b0);
    check("R9 gated trigger ignored", int'(v_cnt), 5);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    #2;
    t_reset();
    t_line();
    t_frame();
    t_trigger();
    t_last_line();
    t_std();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule